// File: doc/BRIEF.md
# Fibre Channel Word Synchronization Tracker

This block decides whether a receive lane has word synchronization. Upstream logic has already byte-aligned the serial stream and decoded it from 8b/10b. It hands over one 4-character word per strobe, together with three flags:

- the first character is a comma;
- some character carries a running-disparity or code violation;
- a comma sits in a position other than the first.

The tracker counts clean idle ordered sets until it trusts the link. From then on it absorbs isolated errors, and it gives up only after a run of bad words that clean traffic has not paid back.

A word is "bad" when it has a code violation or a misplaced comma. A clean ordered set is a word whose first character is a comma and which is not bad. Three clean ordered sets in a row raise the sync flag. Any bad word during that search sends the tracker back to the start.

While in sync, every bad word pushes the tracker one error level deeper. There are three error levels. A bad word at the third level drops sync. Each pair of consecutive good words earns back one level.

The sync flag and the 3-bit state code are both registered. Both change on the clock edge that accepts the word.

Top module: `fc_wsync_fsm`

## Requirements
- R1: With `rst` high at a clock edge, the state code becomes 0 (loss of sync) and `word_sync` becomes 0.
- R2: State codes are: 0 loss of sync, 1 one ordered set seen, 2 two ordered sets seen, 3 synchronized clean, 4 first error level, 5 second error level, 6 third error level. `word_sync` is 1 exactly when the code is 3 to 6.
- R3: A clean ordered set (`first_comma`=1, `code_viol`=0, `mis_comma`=0) moves the code from 0 to 1, from 1 to 2 and from 2 to 3.
- R4: A bad word (`code_viol`=1 or `mis_comma`=1) in state 1 or 2 returns the code to 0. A word with `first_comma`=1 that is also bad leaves state 0 unchanged.
- R5: A good word without a leading comma leaves states 1 and 2 unchanged. Any good word leaves state 3 unchanged.
- R6: A bad word moves the code from 3 to 4, from 4 to 5, from 5 to 6, and from 6 to 0. The last step also drops `word_sync`.
- R7: In states 4 to 6, two consecutive good words move the code up one level (6 to 5, 5 to 4, 4 to 3). The level changes on the second word of the pair.
- R8: In an error level, a good word followed by a bad word earns no credit. The bad word deepens the level and clears the good-word count, so another full pair is then needed.
- R9: When `word_vld` is 0, the state and `word_sync` hold, whatever the flags carry.
- R10: When `enable` is 0 at a clock edge, the code becomes 0 and `word_sync` becomes 0.
- R11: The state code and `word_sync` change on the same clock edge that samples the accepted word, with no further latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Tracker enable; low forces loss of sync |
| word_vld | input | 1 | Strobe marking a received word on this cycle |
| first_comma | input | 1 | First character of the word is a comma |
| code_viol | input | 1 | Some character has a disparity or code violation |
| mis_comma | input | 1 | A comma appears in a non-first position |
| word_sync | output | 1 | Word synchronization achieved |
| state_code | output | 3 | Current tracker state, encoded as in R2 |

## Verification
Several rules are local and are checked on every cycle by the assertions:

- the state code never reaches 7, and `word_sync` agrees with it;
- reset and a low enable force loss of sync;
- an idle strobe holds the state;
- a bad word either restarts acquisition or deepens the error level by exactly one.

The credit rules depend on history. These are the need for two *consecutive* good words, the loss of a half-earned credit on an error, and the ordering of the acquisition count. Only the bench's sequences show them, because they walk the tracker through whole runs of words and compare the code after each one.

// File: rtl/fc_wsync_pkg.sv
package fc_wsync_pkg;
  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_LOS  = 3'd0,
    ST_ACQ1 = 3'd1,
    ST_ACQ2 = 3'd2,
    ST_SYNC = 3'd3,
    ST_ERR1 = 3'd4,
    ST_ERR2 = 3'd5,
    ST_ERR3 = 3'd6
  } wsync_state_e;

  function automatic logic is_synced(input wsync_state_e s);
    return (s == ST_SYNC) || (s == ST_ERR1) || (s == ST_ERR2) || (s == ST_ERR3);
  endfunction

  function automatic logic is_err(input wsync_state_e s);
    return (s == ST_ERR1) || (s == ST_ERR2) || (s == ST_ERR3);
  endfunction
endpackage

// File: rtl/fc_word_class.sv
// Classifies one strobed word into bad / clean ordered set / good.
module fc_word_class (
  input  logic word_vld,
  input  logic first_comma,
  input  logic code_viol,
  input  logic mis_comma,
  output logic step_bad,
  output logic step_os,
  output logic step_good
);
  logic bad;

  always_comb begin
    bad       = code_viol | mis_comma;
    step_bad  = word_vld & bad;
    step_good = word_vld & ~bad;
    step_os   = word_vld & ~bad & first_comma;
  end
endmodule

// File: rtl/fc_credit_ctr.sv
// Counts consecutive good words inside an error level and emits a credit.
module fc_credit_ctr #(
  parameter int PAIR_LEN = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic in_err,
  input  logic step_good,
  input  logic step_bad,
  output logic credit
);
  localparam int CW = (PAIR_LEN > 1) ? $clog2(PAIR_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(PAIR_LEN - 1);

  logic [CW-1:0] cnt;

  always_comb credit = in_err & step_good & (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      cnt <= '0;
    end else if (!in_err || step_bad) begin
      cnt <= '0;
    end else if (step_good) begin
      if (credit) cnt <= '0;
      else        cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/fc_sync_core.sv
// State register and transition logic for the synchronization tracker.
module fc_sync_core
  import fc_wsync_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         enable,
  input  logic         step_bad,
  input  logic         step_os,
  input  logic         credit,
  output wsync_state_e state,
  output logic         sync_q
);
  wsync_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_LOS:  if (step_os) nxt = ST_ACQ1;
      ST_ACQ1: if (step_bad) nxt = ST_LOS;  else if (step_os) nxt = ST_ACQ2;
      ST_ACQ2: if (step_bad) nxt = ST_LOS;  else if (step_os) nxt = ST_SYNC;
      ST_SYNC: if (step_bad) nxt = ST_ERR1;
      ST_ERR1: if (step_bad) nxt = ST_ERR2; else if (credit) nxt = ST_SYNC;
      ST_ERR2: if (step_bad) nxt = ST_ERR3; else if (credit) nxt = ST_ERR1;
      ST_ERR3: if (step_bad) nxt = ST_LOS;  else if (credit) nxt = ST_ERR2;
      default: nxt = ST_LOS;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      state  <= ST_LOS;
      sync_q <= 1'b0;
    end else begin
      state  <= nxt;
      sync_q <= is_synced(nxt);
    end
  end
endmodule

// File: rtl/fc_wsync_fsm.sv
module fc_wsync_fsm
  import fc_wsync_pkg::*;
#(
  parameter int PAIR_LEN = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enable,
  input  logic               word_vld,
  input  logic               first_comma,
  input  logic               code_viol,
  input  logic               mis_comma,
  output logic               word_sync,
  output logic [STATE_W-1:0] state_code
);
  logic         step_bad, step_os, step_good, credit;
  wsync_state_e state;
  logic         sync_q;

  fc_word_class u_class (
    .word_vld    (word_vld),
    .first_comma (first_comma),
    .code_viol   (code_viol),
    .mis_comma   (mis_comma),
    .step_bad    (step_bad),
    .step_os     (step_os),
    .step_good   (step_good)
  );

  fc_credit_ctr #(.PAIR_LEN(PAIR_LEN)) u_credit (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .in_err    (is_err(state)),
    .step_good (step_good),
    .step_bad  (step_bad),
    .credit    (credit)
  );

  fc_sync_core u_core (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .step_bad (step_bad),
    .step_os  (step_os),
    .credit   (credit),
    .state    (state),
    .sync_q   (sync_q)
  );

  assign word_sync  = sync_q;
  assign state_code = state;
endmodule

// File: rtl/fc_wsync_checker.sv
module fc_wsync_checker (
  input logic       clk,
  input logic       rst,
  input logic       enable,
  input logic       word_vld,
  input logic       code_viol,
  input logic       mis_comma,
  input logic       word_sync,
  input logic [2:0] state_code
);
  logic bad;
  assign bad = word_vld & (code_viol | mis_comma);

  a_r1_reset_los: assert property (@(posedge clk)
    rst |=> (state_code == 3'd0 && !word_sync));

  a_r2_code_range: assert property (@(posedge clk) disable iff (rst)
    state_code != 3'd7);

  a_r2_sync_matches_code: assert property (@(posedge clk) disable iff (rst)
    word_sync == (state_code >= 3'd3 && state_code <= 3'd6));

  a_r4_bad_restarts_acq: assert property (@(posedge clk) disable iff (rst)
    (enable && bad && (state_code == 3'd1 || state_code == 3'd2)) |=> state_code == 3'd0);

  a_r6_bad_deepens: assert property (@(posedge clk) disable iff (rst)
    (enable && bad && state_code >= 3'd3 && state_code <= 3'd5)
      |=> state_code == $past(state_code) + 3'd1);

  a_r6_third_error_drops: assert property (@(posedge clk) disable iff (rst)
    (enable && bad && state_code == 3'd6) |=> (state_code == 3'd0 && !word_sync));

  a_r9_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (enable && !word_vld) |=> $stable(state_code));

  a_r10_disable_los: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (state_code == 3'd0 && !word_sync));
endmodule

bind fc_wsync_fsm fc_wsync_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .enable     (enable),
  .word_vld   (word_vld),
  .code_viol  (code_viol),
  .mis_comma  (mis_comma),
  .word_sync  (word_sync),
  .state_code (state_code)
);

// File: tb/fc_wsync_fsm_bench.sv
module fc_wsync_fsm_bench;
  logic       clk = 1'b0;
  logic       rst, enable, word_vld, first_comma, code_viol, mis_comma;
  logic       word_sync;
  logic [2:0] state_code;
  int         n_chk = 0;
  int         n_bad = 0;

  always #10 clk = ~clk;   // 50 MHz

  fc_wsync_fsm u_fc_wsync_fsm (
    .clk         (clk),
    .rst         (rst),
    .enable      (enable),
    .word_vld    (word_vld),
    .first_comma (first_comma),
    .code_viol   (code_viol),
    .mis_comma   (mis_comma),
    .word_sync   (word_sync),
    .state_code  (state_code)
  );

  // Vector fields: {rst, enable, vld, first_comma, code_viol, mis_comma, expected_state[2:0]}
  localparam int NV = 29;
  localparam logic [8:0] VEC [NV] = '{
    9'b1_0_0_0_0_0_000, // R1 reset
    9'b0_1_1_1_0_0_001, // R3 OS
    9'b0_1_1_1_0_0_010, // R3 OS
    9'b0_1_1_0_0_0_010, // R5 plain good word in acquisition
    9'b0_1_1_1_0_0_011, // R3 sync reached
    9'b0_1_1_0_0_0_011, // R5 good in sync
    9'b0_1_1_0_1_0_100, // R6 error 1
    9'b0_1_1_0_0_0_100, // R7 first good
    9'b0_1_1_0_0_0_011, // R7 credit back to sync
    9'b0_1_1_0_1_0_100, // R6
    9'b0_1_1_0_0_0_100, // R8 half credit
    9'b0_1_1_0_1_0_101, // R8 bad clears count, deeper
    9'b0_1_1_0_0_1_110, // R6 misplaced comma deepens
    9'b0_1_1_0_0_0_110, // R8 needs a full pair again
    9'b0_1_1_0_0_0_101, // R7 credit 6->5
    9'b0_1_0_0_1_0_101, // R9 no strobe
    9'b0_1_1_0_1_0_110, // R6
    9'b0_1_1_0_1_0_000, // R6 fourth bad drops
    9'b0_1_1_1_0_0_001, // R3
    9'b0_1_1_0_1_0_000, // R4 violation in acquisition
    9'b0_1_1_1_1_0_000, // R4 bad comma word in LOS
    9'b0_1_1_1_0_0_001, // R3
    9'b0_1_1_1_0_0_010, // R3
    9'b0_1_1_0_0_1_000, // R4 misplaced comma in ACQ2
    9'b0_1_1_1_0_0_001, // R3
    9'b0_0_1_1_0_0_000, // R10 enable low
    9'b0_1_1_1_0_0_001, // R3
    9'b0_1_1_1_0_0_010, // R3
    9'b0_1_1_1_0_0_011  // R11 same-edge update
  };

  task automatic drive(input logic r, e, v, f, c, m);
    @(negedge clk);
    rst = r; enable = e; word_vld = v; first_comma = f; code_viol = c; mis_comma = m;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [2:0] exp);
    logic exp_sync;
    exp_sync = (exp >= 3'd3);
    n_chk++;
    if (state_code !== exp || word_sync !== exp_sync) begin
      n_bad++;
      $display("FAIL %s: state=%0d sync=%0b expected state=%0d sync=%0b",
               tag, state_code, word_sync, exp, exp_sync);
    end
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; enable = 1'b0; word_vld = 1'b0;
    first_comma = 1'b0; code_viol = 1'b0; mis_comma = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    check("R1 reset state", 3'd0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][8], VEC[i][7], VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3]);
      check($sformatf("R2 vector %0d", i), VEC[i][2:0]);
    end

    // R1: reset from a deep error level
    drive(0, 1, 1, 0, 1, 0);
    check("R6 sync to err1", 3'd4);
    drive(1, 1, 1, 1, 0, 0);
    check("R1 reset from error level", 3'd0);

    // R9: long idle strobe in ACQ2 with junk flags
    drive(0, 1, 1, 1, 0, 0);
    drive(0, 1, 1, 1, 0, 0);
    for (int k = 0; k < 4; k++) drive(0, 1, 0, k[0], 1, k[1]);
    check("R9 idle holds ACQ2", 3'd2);

    // R7: climb from err3 all the way back to clean sync
    drive(0, 1, 1, 1, 0, 0);
    for (int k = 0; k < 3; k++) drive(0, 1, 1, 0, 1, 0);
    check("R6 third error level", 3'd6);
    for (int k = 0; k < 6; k++) drive(0, 1, 1, 0, 0, 0);
    check("R7 three credits restore sync", 3'd3);

    // R7: idle gaps between pair members still count as consecutive good words
    drive(0, 1, 1, 0, 1, 0);
    drive(0, 1, 1, 0, 0, 0);
    drive(0, 1, 0, 0, 0, 0);
    drive(0, 1, 1, 0, 0, 0);
    check("R7 pair across idle gap", 3'd3);

    // R10: disable mid-error
    drive(0, 1, 1, 0, 1, 0);
    drive(0, 0, 1, 0, 0, 0);
    check("R10 disable in error level", 3'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule